// File: doc/BRIEF.md
# Execution Trace Capture Unit

This unit sits next to a monitored processor core and turns its checkpoint events into a compact timing trace. The core raises a registration strobe once when a protected process starts; the unit then remembers that process identifier and uses the program counter of that event as its base address. Every later checkpoint strobe from the same process stores one record holding the distance between the base address and the checkpoint's program counter, together with the cycle timestamp seen in the same clock cycle.

Records go into a private circular buffer in arrival order. Only the secure side can drain it, through a show-ahead read port with a pop strobe. Checkpoints from any other process are dropped, so a task that has not registered cannot forge a trace. A sticky overflow flag reports records lost because the buffer was full. A sticky flag also reports checkpoints that arrived before any registration. One acknowledge strobe from the secure side clears both flags. The reset input is taken as already synchronized to the clock on release.

Top module: `trace_capture_unit`

## Requirements
- R1: After reset the read port shows no record (rd_valid low), and ovf_flag and unreg_flag are low.
- R2: A registration strobe stores core_pid and takes core_pc as base address. A later trace strobe carrying the same core_pid appends a record whose offset field is (base minus trace core_pc) modulo 2^ADDR_W.
- R3: A record's timestamp field equals the value of cycle_ts in the clock cycle in which its trace strobe is sampled.
- R4: Records come out in arrival order. While no pop and no registration occur, the record shown at the read port does not change.
- R5: After a registration, a trace strobe whose core_pid differs from the registered identifier stores nothing and raises no flag.
- R6: A trace strobe before any registration since reset stores nothing and sets unreg_flag.
- R7: The buffer holds DEPTH (64) records. A trace that arrives while DEPTH records are held is dropped and sets ovf_flag, and the held records stay intact. ovf_flag stays set until acknowledged.
- R8: A sec_ack strobe clears ovf_flag and unreg_flag in the next cycle. If a setting event occurs in the same cycle, the set wins.
- R9: A registration strobe empties the buffer and replaces the stored identifier and base address. Later traces are checked and offset against the new values.
- R10: A pop strobe while rd_valid is low has no effect.
- R11: When registration and trace strobes fall in the same cycle, the registration takes effect and the trace is dropped.
- R12: A pop and an accepted trace in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| reg_stb | input | 1 | Process registration strobe from the monitored core |
| trc_stb | input | 1 | Checkpoint trace strobe from the monitored core |
| core_pc | input | ADDR_W | Program counter accompanying either strobe |
| core_pid | input | PID_W | Process identifier accompanying either strobe |
| cycle_ts | input | TS_W | Free-running cycle timestamp |
| sec_rd_en | input | 1 | Secure-side pop of the record at the read port |
| sec_ack | input | 1 | Secure-side acknowledge that clears both flags |
| rd_valid | output | 1 | A record is present at the read port |
| rd_ofs | output | ADDR_W | Offset field of the oldest record |
| rd_ts | output | TS_W | Timestamp field of the oldest record |
| ovf_flag | output | 1 | Sticky: a record was dropped because the buffer was full |
| unreg_flag | output | 1 | Sticky: a trace arrived before any registration |

## Verification
A corrupted pointer or count shows at the read port in the cycle after the event that caused it. Records come out missing, repeated or out of order, or rd_valid stays high on an empty buffer. A stale identifier or base address shows in the first record after a re-registration, as a dropped record or a wrong offset. Filling the buffer to exactly its depth and then draining it tests the wrap of both pointers and the full/empty boundary on every slot.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  // Admission state of the registration filter
  typedef enum logic [0:0] {
    ADM_IDLE  = 1'b0,
    ADM_ARMED = 1'b1
  } adm_state_e;

  // Events that feed the sticky flags
  typedef struct packed {
    logic drop_full;
    logic unreg_hit;
  } tcu_evt_t;

endpackage

// File: rtl/tcu_admit.sv
module tcu_admit #(
  parameter int ADDR_W = 16,
  parameter int PID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_stb,
  input  logic              trc_stb,
  input  logic [ADDR_W-1:0] core_pc,
  input  logic [PID_W-1:0]  core_pid,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_ofs,
  output logic              ring_clear,
  output logic              unreg_hit
);
  import tcu_pkg::*;

  adm_state_e        state_q, state_d;
  logic [PID_W-1:0]  pid_q, pid_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              trc_only;
  logic              pid_match;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pid_d   = pid_q;
    base_d  = base_q;
    if (reg_stb) begin
      state_d = ADM_ARMED;
      pid_d   = core_pid;
      base_d  = core_pc;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ADM_IDLE;
      pid_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (reg_stb) begin
        pid_q  <= pid_d;
        base_q <= base_d;
      end
    end
  end

  // Admission decision; registration in the same cycle wins
  assign trc_only   = trc_stb && !reg_stb;
  assign pid_match  = (core_pid == pid_q);
  assign wr_req     = trc_only && (state_q == ADM_ARMED) && pid_match;
  assign unreg_hit  = trc_only && (state_q == ADM_IDLE);
  assign ring_clear = reg_stb;
  assign wr_ofs     = base_q - core_pc;

endmodule

// File: rtl/tcu_ring.sv
module tcu_ring #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 16,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_ofs,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_ofs,
  output logic [TS_W-1:0]   rd_ts,
  output logic              full_drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int REC_W = ADDR_W + TS_W;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             is_full, is_empty;
  logic             do_wr, do_pop;
  logic [REC_W-1:0] head;

  assign is_full  = (cnt_q == FULL_CNT);
  assign is_empty = (cnt_q == '0);
  assign do_wr    = wr_req && !is_full && !clear;
  assign do_pop   = rd_pop && !is_empty && !clear;
  assign full_drop = wr_req && is_full && !clear;

  // Next-state logic for pointers and occupancy
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clear) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_wr) begin
        wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      end
      if (do_pop) begin
        rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      end
      case ({do_wr, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array: written only on an accepted record
  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[wr_ptr_q] <= {wr_ofs, wr_ts};
    end
  end

  // Show-ahead read of the oldest record
  assign head     = mem[rd_ptr_q];
  assign rd_valid = !is_empty;
  assign rd_ofs   = head[REC_W-1:TS_W];
  assign rd_ts    = head[TS_W-1:0];

endmodule

// File: rtl/tcu_flags.sv
module tcu_flags (
  input  logic            clk,
  input  logic            rst_n,
  input  tcu_pkg::tcu_evt_t evt,
  input  logic            ack,
  output logic            ovf_flag,
  output logic            unreg_flag
);
  logic ovf_q, ovf_d;
  logic unreg_q, unreg_d;

  // Set has priority over acknowledge
  always_comb begin
    ovf_d   = (ovf_q   && !ack) || evt.drop_full;
    unreg_d = (unreg_q && !ack) || evt.unreg_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      unreg_q <= 1'b0;
    end else begin
      ovf_q   <= ovf_d;
      unreg_q <= unreg_d;
    end
  end

  assign ovf_flag   = ovf_q;
  assign unreg_flag = unreg_q;

endmodule

// File: rtl/trace_capture_unit.sv
module trace_capture_unit #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 16,
  parameter int PID_W  = 8,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_stb,
  input  logic              trc_stb,
  input  logic [ADDR_W-1:0] core_pc,
  input  logic [PID_W-1:0]  core_pid,
  input  logic [TS_W-1:0]   cycle_ts,
  input  logic              sec_rd_en,
  input  logic              sec_ack,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_ofs,
  output logic [TS_W-1:0]   rd_ts,
  output logic              ovf_flag,
  output logic              unreg_flag
);
  import tcu_pkg::*;

  logic              wr_req;
  logic [ADDR_W-1:0] wr_ofs;
  logic              ring_clear;
  logic              unreg_hit;
  logic              full_drop;
  tcu_evt_t          evt;

  tcu_admit #(
    .ADDR_W(ADDR_W),
    .PID_W (PID_W)
  ) u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_stb   (reg_stb),
    .trc_stb   (trc_stb),
    .core_pc   (core_pc),
    .core_pid  (core_pid),
    .wr_req    (wr_req),
    .wr_ofs    (wr_ofs),
    .ring_clear(ring_clear),
    .unreg_hit (unreg_hit)
  );

  tcu_ring #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .TS_W  (TS_W)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ring_clear),
    .wr_req   (wr_req),
    .wr_ofs   (wr_ofs),
    .wr_ts    (cycle_ts),
    .rd_pop   (sec_rd_en),
    .rd_valid (rd_valid),
    .rd_ofs   (rd_ofs),
    .rd_ts    (rd_ts),
    .full_drop(full_drop)
  );

  assign evt.drop_full = full_drop;
  assign evt.unreg_hit = unreg_hit;

  tcu_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .ack       (sec_ack),
    .ovf_flag  (ovf_flag),
    .unreg_flag(unreg_flag)
  );

endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int ADDR_W = 16,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_stb,
  input logic              trc_stb,
  input logic              sec_rd_en,
  input logic              sec_ack,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_ofs,
  input logic [TS_W-1:0]   rd_ts,
  input logic              ovf_flag,
  input logic              unreg_flag
);

  assert_reg_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb |=> !rd_valid);

  assert_reg_beats_trace_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_stb && trc_stb) |=> (!rd_valid && !unreg_flag || $past(unreg_flag)));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !sec_ack) |=> ovf_flag);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_ack && !trc_stb) |=> (!ovf_flag && !unreg_flag));

  assert_unreg_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unreg_flag) |-> $past(trc_stb));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && sec_rd_en && !trc_stb) |=> !rd_valid);

  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !sec_rd_en && !reg_stb) |=>
      (rd_valid && $stable(rd_ofs) && $stable(rd_ts)));

endmodule

bind trace_capture_unit tcu_checker #(
  .ADDR_W(ADDR_W),
  .TS_W  (TS_W)
) u_tcu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_stb   (reg_stb),
  .trc_stb   (trc_stb),
  .sec_rd_en (sec_rd_en),
  .sec_ack   (sec_ack),
  .rd_valid  (rd_valid),
  .rd_ofs    (rd_ofs),
  .rd_ts     (rd_ts),
  .ovf_flag  (ovf_flag),
  .unreg_flag(unreg_flag)
);

// File: tb/trace_capture_unit_test.sv
`timescale 1ns/1ps
module trace_capture_unit_test;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 16;
  localparam int PID_W  = 8;
  localparam int TS_W   = 32;

  logic              clk;
  logic              rst_n;
  logic              reg_stb;
  logic              trc_stb;
  logic [ADDR_W-1:0] core_pc;
  logic [PID_W-1:0]  core_pid;
  logic [TS_W-1:0]   cycle_ts;
  logic              sec_rd_en;
  logic              sec_ack;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_ofs;
  logic [TS_W-1:0]   rd_ts;
  logic              ovf_flag;
  logic              unreg_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  trace_capture_unit #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PID_W(PID_W), .TS_W(TS_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reg_stb(reg_stb), .trc_stb(trc_stb),
    .core_pc(core_pc), .core_pid(core_pid), .cycle_ts(cycle_ts),
    .sec_rd_en(sec_rd_en), .sec_ack(sec_ack), .rd_valid(rd_valid),
    .rd_ofs(rd_ofs), .rd_ts(rd_ts), .ovf_flag(ovf_flag), .unreg_flag(unreg_flag)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_stb = 0; trc_stb = 0; sec_rd_en = 0; sec_ack = 0;
    core_pc = '0; core_pid = '0; cycle_ts = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reg(input logic [PID_W-1:0] pid, input logic [ADDR_W-1:0] pc);
    @(negedge clk);
    reg_stb = 1; core_pid = pid; core_pc = pc;
    @(negedge clk);
    reg_stb = 0;
  endtask

  task automatic do_trc(input logic [PID_W-1:0] pid, input logic [ADDR_W-1:0] pc,
                        input logic [TS_W-1:0] ts);
    @(negedge clk);
    trc_stb = 1; core_pid = pid; core_pc = pc; cycle_ts = ts;
    @(negedge clk);
    trc_stb = 0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    sec_ack = 1;
    @(negedge clk);
    sec_ack = 0;
  endtask

  task automatic pop_expect(input string req, input logic [ADDR_W-1:0] ofs,
                            input logic [TS_W-1:0] ts);
    @(negedge clk);
    chk({req, " valid"}, 64'(rd_valid), 64'd1);
    chk({req, " ofs"}, 64'(rd_ofs), 64'(ofs));
    chk({req, " ts"}, 64'(rd_ts), 64'(ts));
    sec_rd_en = 1;
    @(negedge clk);
    sec_rd_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid", 64'(rd_valid), 64'd0);
    chk("R1 ovf", 64'(ovf_flag), 64'd0);
    chk("R1 unreg", 64'(unreg_flag), 64'd0);
  endtask

  task automatic t_unregistered();
    do_reset();
    do_trc(8'd1, 16'h0040, 32'd7);
    chk("R6 valid", 64'(rd_valid), 64'd0);
    chk("R6 unreg", 64'(unreg_flag), 64'd1);
    do_ack();
    chk("R8 unreg cleared", 64'(unreg_flag), 64'd0);
  endtask

  task automatic t_basic();
    logic [ADDR_W-1:0] base = 16'h1000;
    do_reset();
    do_reg(8'd5, base);
    do_trc(8'd5, 16'h0F80, 32'd100);
    do_trc(8'd5, 16'h0F00, 32'd250);
    do_trc(8'd5, 16'h1010, 32'hDEAD_0001);
    pop_expect("R2 R4 first", base - 16'h0F80, 32'd100);
    pop_expect("R3 R4 second", base - 16'h0F00, 32'd250);
    pop_expect("R2 wrap offset", base - 16'h1010, 32'hDEAD_0001);
    chk("R4 drained", 64'(rd_valid), 64'd0);
    // Pop on empty buffer, then a new record must still come out first
    @(negedge clk); sec_rd_en = 1; @(negedge clk); sec_rd_en = 0;
    chk("R10 empty pop", 64'(rd_valid), 64'd0);
    do_trc(8'd5, 16'h0FF0, 32'd400);
    pop_expect("R10 after empty pop", 16'h0010, 32'd400);
    chk("R1 no unreg", 64'(unreg_flag), 64'd0);
  endtask

  task automatic t_forged();
    do_reset();
    do_reg(8'd5, 16'h2000);
    do_trc(8'd6, 16'h1F00, 32'd11);
    chk("R5 valid", 64'(rd_valid), 64'd0);
    chk("R5 unreg", 64'(unreg_flag), 64'd0);
    chk("R5 ovf", 64'(ovf_flag), 64'd0);
  endtask

  task automatic t_full();
    do_reset();
    do_reg(8'd7, 16'h8000);
    for (int i = 0; i < DEPTH; i++) begin
      do_trc(8'd7, 16'h8000 - 16'(i), 32'(i));
    end
    chk("R7 no ovf at depth", 64'(ovf_flag), 64'd0);
    do_trc(8'd7, 16'h7000, 32'd999);
    chk("R7 ovf set", 64'(ovf_flag), 64'd1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_expect("R7 kept record", 16'(i), 32'(i));
    end
    chk("R7 dropped record absent", 64'(rd_valid), 64'd0);
    chk("R7 ovf sticky", 64'(ovf_flag), 64'd1);
    do_ack();
    chk("R8 ovf cleared", 64'(ovf_flag), 64'd0);
  endtask

  task automatic t_ack_vs_set();
    do_reset();
    @(negedge clk);
    sec_ack = 1; trc_stb = 1; core_pid = 8'd3; core_pc = 16'h0; cycle_ts = 32'd1;
    @(negedge clk);
    sec_ack = 0; trc_stb = 0;
    chk("R8 set wins", 64'(unreg_flag), 64'd1);
  endtask

  task automatic t_rereg();
    do_reset();
    do_reg(8'd2, 16'h3000);
    do_trc(8'd2, 16'h2FF0, 32'd5);
    do_trc(8'd2, 16'h2FE0, 32'd6);
    do_reg(8'd3, 16'h5000);
    chk("R9 emptied", 64'(rd_valid), 64'd0);
    do_trc(8'd2, 16'h4FF0, 32'd7);
    chk("R9 old pid rejected", 64'(rd_valid), 64'd0);
    do_trc(8'd3, 16'h4F00, 32'd8);
    pop_expect("R9 new base", 16'h0100, 32'd8);
  endtask

  task automatic t_same_cycle();
    do_reset();
    do_reg(8'd4, 16'h0100);
    do_trc(8'd4, 16'h00F0, 32'd20);
    @(negedge clk);
    reg_stb = 1; trc_stb = 1; core_pid = 8'd4; core_pc = 16'h0200; cycle_ts = 32'd21;
    @(negedge clk);
    reg_stb = 0; trc_stb = 0;
    chk("R11 trace dropped", 64'(rd_valid), 64'd0);
    chk("R11 no unreg", 64'(unreg_flag), 64'd0);
    do_trc(8'd4, 16'h01F8, 32'd22);
    pop_expect("R11 new base used", 16'h0008, 32'd22);
  endtask

  task automatic t_push_pop();
    do_reset();
    do_reg(8'd9, 16'h0100);
    do_trc(8'd9, 16'h00F0, 32'd10);
    @(negedge clk);
    sec_rd_en = 1; trc_stb = 1; core_pid = 8'd9; core_pc = 16'h00E0; cycle_ts = 32'd20;
    @(negedge clk);
    sec_rd_en = 0; trc_stb = 0;
    pop_expect("R12 new head", 16'h0020, 32'd20);
    chk("R12 empty after", 64'(rd_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_stb = 0; trc_stb = 0; sec_rd_en = 0; sec_ack = 0;
    core_pc = '0; core_pid = '0; cycle_ts = '0;
    t_reset();
    t_unregistered();
    t_basic();
    t_forged();
    t_full();
    t_ack_vs_set();
    t_rereg();
    t_same_cycle();
    t_push_pop();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule